// File: doc/BRIEF.md
# Sectionalized Multi-Port MDIO Management Slave

This block is the management front end of an eight-port Ethernet PHY. It listens to one or two serial management channels. Each channel has a management clock input and a bidirectional data line, split here into an input, an output value and an output enable. The block decodes Clause 22 style read and write frames. It maps the PHY address of each frame onto one of eight ports, and reads or writes a small register file held for each port. For every channel it also raises an active-low, open-drain interrupt, modelled as a pull-low enable.

A section strap picks the channel layout. In shared mode, channel 0 alone serves all eight ports and channel 1 stays silent. In split mode, channel 0 serves ports 0 to 3 and channel 1 serves ports 4 to 7, each clocked by its own management clock. Strap pins supply the reset value of each port's control register. A management-disable strap can instead pin those registers to the straps for good and silence both channels. A power-down input releases every output.

The management clock and data inputs are oversampled with the system clock `clk`. The management clock must stay high and low for at least three `clk` cycles per phase.

Top module: `mdio_sect_slave`

## Requirements
- R1: After reset, every `mdioOe` and `intLowOe` bit is 0. Within two clock cycles, each port's control register (reg 0) holds `strapCtrl`. The interrupt config (reg 18) and interrupt status (reg 19) read 0.
- R2: A frame is sampled on rising management clock edges. It is 32 ones, then start bits 0 and 1, a 2-bit opcode (10 read, 01 write), a 5-bit PHY address, a 5-bit register number, 2 turnaround bits, then 16 data bits, MSB first. Port p answers PHY address `BASE_ADDR`+p. A write to reg 0 of port p appears on `ctrlOut[16p+15:16p]`.
- R3: On a read to a served port, the slave leaves the line released during the first turnaround bit and drives 0 during the second. It then drives data bits 15 down to 0, each updated after a rising clock edge. It releases the line after bit 0.
- R4: With `sectionMode`=0, channel 0 reaches all eight ports. Channel 1 never drives its data line or its interrupt, and its frames change nothing.
- R5: With `sectionMode`=1, channel 0 serves ports 0-3 and channel 1 serves ports 4-7. A frame on one channel to a port of the other group is not driven and writes nothing.
- R6: Frames to PHY addresses outside the eight ports, and frames with opcode 00 or 11, get no drive and cause no write.
- R7: Reg 0 and reg 18 are read/write, and bit 1 of reg 18 enables the port's interrupt. Reg 19 is read-only and returns the port's status-change flag in bit 0. Every other register reads 0 and ignores writes.
- R8: A one-cycle pulse on `statusEvent[p]` sets the flag of port p. A read of reg 19 of that port returns the flag and clears it.
- R9: `intLowOe[c]` is 1 exactly when some port in channel c's group has its flag set and bit 1 of its reg 18 set.
- R10: While `mgmtDisable` is 1, neither channel drives or accepts frames, and `ctrlOut` follows `strapCtrl` continuously.
- R11: While `mgmtDisable` is 0, changes on `strapCtrl` after reset leave the registers unchanged.
- R12: While `powerDown` is 1, all `mdioOe` and `intLowOe` bits are 0 and frames are ignored. Register contents and pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the management clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sectionMode | input | 1 | 0: one channel for eight ports; 1: two channels of four ports |
| mgmtDisable | input | 1 | Management disable strap |
| powerDown | input | 1 | Releases all outputs while high |
| strapCtrl | input | 16 | Strap value for the control register of every port |
| statusEvent | input | 8 | Per-port status-change pulse |
| mdcIn | input | 2 | Management clock of each channel |
| mdioIn | input | 2 | Sensed level of each data line |
| mdioOut | output | 2 | Value driven on each data line |
| mdioOe | output | 2 | Drive enable of each data line |
| intLowOe | output | 2 | Pull-low enable of each channel's interrupt line |
| ctrlOut | output | 128 | Control register of every port, port p at bits 16p+15:16p |

## Verification
The assertions take the straps `sectionMode` and `mgmtDisable` as static between resets. They also assume each management clock phase lasts long enough for the synchronizers to see it, so that a channel's first driven bit is always the zero turnaround bit. The bench changes the straps only while reset is held. It drives each management clock with four system clocks per phase, and changes data only while the management clock is low. It samples the line just before the next rising edge, as a master would.

// File: rtl/mdio_sect_pkg.sv
package mdio_sect_pkg;
  localparam int PORTS  = 8;
  localparam int CHANS  = 2;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int PORT_W = $clog2(PORTS);
  localparam int GROUP  = PORTS / CHANS;
  localparam int PRE_LEN = 32;
  localparam int INT_EN_BIT = 1;

  localparam logic [ADDR_W-1:0] REG_CTRL     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_INT_CFG  = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] REG_INT_STAT = ADDR_W'(19);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_TA, S_DATA
  } frameState_t;

  typedef struct packed {
    logic              rdEn;
    logic              wrEn;
    logic [PORT_W-1:0] port;
    logic [ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0] wrData;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_chan_ctrl.sv
module mdio_chan_ctrl
  import mdio_sect_pkg::*;
#(
  parameter int                CHAN      = 0,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              sectionMode,
  input  logic              mdcIn,
  input  logic              mdioIn,
  input  logic [DATA_W-1:0] rdData,
  output mdioStrobe_t       strb,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam logic [ADDR_W-1:0] PORT_LIM = ADDR_W'(PORTS);
  localparam logic [PORT_W-1:0] GRP_LIM  = PORT_W'(GROUP);
  localparam int                PRE_W    = $clog2(PRE_LEN) + 1;
  localparam logic [PRE_W-1:0]  PRE_FULL = PRE_W'(PRE_LEN);

  logic [2:0] mdcSync;
  logic [1:0] dinSync;
  logic       rise, bitIn;

  frameState_t       state;
  logic [PRE_W-1:0]  preCnt;
  logic [3:0]        cnt;
  logic [10:0]       hdrSh;
  logic [DATA_W-1:0] dataSh;
  logic              isWrite, hitQ;
  logic [PORT_W-1:0] portQ;
  logic [ADDR_W-1:0] regQ;

  logic [11:0]       hdrWord;
  logic [1:0]        opCode;
  logic [ADDR_W-1:0] phyAddr, regAddr, idx;
  logic [PORT_W-1:0] portIdx;
  logic              inRange, hitNow, opRead, opWrite, decodeEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcSync <= '0;
      dinSync <= '1;
    end else begin
      mdcSync <= {mdcSync[1:0], mdcIn};
      dinSync <= {dinSync[0], mdioIn};
    end
  end

  assign rise  = mdcSync[1] & ~mdcSync[2];
  assign bitIn = dinSync[1];

  assign hdrWord = {hdrSh, bitIn};
  assign opCode  = hdrWord[11:10];
  assign phyAddr = hdrWord[9:5];
  assign regAddr = hdrWord[4:0];
  assign idx     = phyAddr - BASE_ADDR;
  assign portIdx = idx[PORT_W-1:0];
  assign inRange = (phyAddr >= BASE_ADDR) && (idx < PORT_LIM);
  assign opRead  = (opCode == 2'b10);
  assign opWrite = (opCode == 2'b01);

  generate
    if (CHAN == 0) begin : g_lowGroup
      assign hitNow = inRange && (!sectionMode || portIdx < GRP_LIM);
    end else begin : g_highGroup
      assign hitNow = inRange && sectionMode && portIdx >= GRP_LIM;
    end
  endgenerate

  assign decodeEdge = rise && state == S_HDR && cnt == 4'd11;

  always_comb begin
    strb.rdEn    = chanEn && decodeEdge && opRead && hitNow;
    strb.wrEn    = chanEn && rise && state == S_DATA && cnt == 4'd15 && isWrite && hitQ;
    strb.port    = decodeEdge ? portIdx : portQ;
    strb.regAddr = decodeEdge ? regAddr : regQ;
    strb.wrData  = {dataSh[DATA_W-2:0], bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      preCnt  <= '0;
      cnt     <= '0;
      hdrSh   <= '0;
      dataSh  <= '0;
      isWrite <= 1'b0;
      hitQ    <= 1'b0;
      portQ   <= '0;
      regQ    <= '0;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else if (!chanEn) begin
      state  <= S_IDLE;
      preCnt <= '0;
      mdioOe <= 1'b0;
    end else if (rise) begin
      case (state)
        S_IDLE: begin
          if (bitIn) begin
            if (preCnt != PRE_FULL) preCnt <= preCnt + 1'b1;
          end else begin
            if (preCnt == PRE_FULL) state <= S_START;
            preCnt <= '0;
          end
        end
        S_START: begin
          state <= bitIn ? S_HDR : S_IDLE;
          cnt   <= '0;
        end
        S_HDR: begin
          hdrSh <= hdrWord[10:0];
          cnt   <= cnt + 1'b1;
          if (cnt == 4'd11) begin
            cnt <= '0;
            if (opRead || opWrite) begin
              state   <= S_TA;
              isWrite <= opWrite;
              hitQ    <= hitNow;
              portQ   <= portIdx;
              regQ    <= regAddr;
              if (opRead && hitNow) dataSh <= rdData;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == 4'd0) begin
            if (!isWrite && hitQ) begin
              mdioOe  <= 1'b1;
              mdioOut <= 1'b0;
            end
          end else begin
            state <= S_DATA;
            cnt   <= '0;
            if (!isWrite && hitQ) begin
              mdioOut <= dataSh[DATA_W-1];
              dataSh  <= {dataSh[DATA_W-2:0], 1'b0};
            end
          end
        end
        S_DATA: begin
          cnt <= cnt + 1'b1;
          if (isWrite) begin
            dataSh <= {dataSh[DATA_W-2:0], bitIn};
          end else begin
            mdioOut <= dataSh[DATA_W-1];
            dataSh  <= {dataSh[DATA_W-2:0], 1'b0};
          end
          if (cnt == 4'd15) begin
            state  <= S_IDLE;
            preCnt <= '0;
            mdioOe <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_port_regs.sv
module mdio_port_regs
  import mdio_sect_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sectionMode,
  input  logic                         mgmtDisable,
  input  logic [DATA_W-1:0]            strapCtrl,
  input  logic [PORTS-1:0]             statusEvent,
  input  mdioStrobe_t [CHANS-1:0]      strb,
  output logic [CHANS-1:0][DATA_W-1:0] rdData,
  output logic [CHANS-1:0]             intLow,
  output logic [PORTS*DATA_W-1:0]      ctrlOut
);
  logic [DATA_W-1:0] ctrlReg [PORTS];
  logic [DATA_W-1:0] intCfg  [PORTS];
  logic [PORTS-1:0]  flag;
  logic [PORTS-1:0]  clrFlag;
  logic              loaded;

  function automatic logic inGroup(input int c, input int p, input logic mode);
    if (c == 0) return !mode || (p < GROUP);
    else        return mode && (p >= GROUP);
  endfunction

  always_comb begin
    clrFlag = '0;
    for (int c = 0; c < CHANS; c++) begin
      for (int p = 0; p < PORTS; p++) begin
        if (strb[c].rdEn && strb[c].port == PORT_W'(p) && strb[c].regAddr == REG_INT_STAT)
          clrFlag[p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded <= 1'b0;
      flag   <= '0;
      for (int p = 0; p < PORTS; p++) begin
        ctrlReg[p] <= '0;
        intCfg[p]  <= '0;
      end
    end else begin
      loaded <= 1'b1;
      for (int p = 0; p < PORTS; p++) begin
        if (!loaded) ctrlReg[p] <= strapCtrl;
        for (int c = 0; c < CHANS; c++) begin
          if (strb[c].wrEn && strb[c].port == PORT_W'(p)) begin
            case (strb[c].regAddr)
              REG_CTRL:    ctrlReg[p] <= strb[c].wrData;
              REG_INT_CFG: intCfg[p]  <= strb[c].wrData;
              default:     ;
            endcase
          end
        end
        if (statusEvent[p])  flag[p] <= 1'b1;
        else if (clrFlag[p]) flag[p] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < CHANS; c++) begin
      case (strb[c].regAddr)
        REG_CTRL:     rdData[c] = ctrlReg[strb[c].port];
        REG_INT_CFG:  rdData[c] = intCfg[strb[c].port];
        REG_INT_STAT: rdData[c] = {{(DATA_W-1){1'b0}}, flag[strb[c].port]};
        default:      rdData[c] = '0;
      endcase
    end
  end

  always_comb begin
    intLow = '0;
    for (int c = 0; c < CHANS; c++) begin
      for (int p = 0; p < PORTS; p++) begin
        if (flag[p] && intCfg[p][INT_EN_BIT] && inGroup(c, p, sectionMode))
          intLow[c] = 1'b1;
      end
    end
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_ctrlOut
      assign ctrlOut[p*DATA_W +: DATA_W] = mgmtDisable ? strapCtrl : ctrlReg[p];
    end
  endgenerate
endmodule

// File: rtl/mdio_sect_slave.sv
module mdio_sect_slave
  import mdio_sect_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sectionMode,
  input  logic                    mgmtDisable,
  input  logic                    powerDown,
  input  logic [DATA_W-1:0]       strapCtrl,
  input  logic [PORTS-1:0]        statusEvent,
  input  logic [CHANS-1:0]        mdcIn,
  input  logic [CHANS-1:0]        mdioIn,
  output logic [CHANS-1:0]        mdioOut,
  output logic [CHANS-1:0]        mdioOe,
  output logic [CHANS-1:0]        intLowOe,
  output logic [PORTS*DATA_W-1:0] ctrlOut
);
  mdioStrobe_t [CHANS-1:0]      strb;
  logic [CHANS-1:0][DATA_W-1:0] rdData;
  logic [CHANS-1:0]             chanEn;
  logic [CHANS-1:0]             chanOe;
  logic [CHANS-1:0]             intLow;

  generate
    for (genvar c = 0; c < CHANS; c++) begin : g_chan
      assign chanEn[c] = !mgmtDisable && !powerDown && ((c == 0) || sectionMode);
      mdio_chan_ctrl #(.CHAN(c), .BASE_ADDR(BASE_ADDR)) u_ctrl (
        .clk        (clk),
        .rstN       (rstN),
        .chanEn     (chanEn[c]),
        .sectionMode(sectionMode),
        .mdcIn      (mdcIn[c]),
        .mdioIn     (mdioIn[c]),
        .rdData     (rdData[c]),
        .strb       (strb[c]),
        .mdioOut    (mdioOut[c]),
        .mdioOe     (chanOe[c])
      );
    end
  endgenerate

  mdio_port_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .sectionMode(sectionMode),
    .mgmtDisable(mgmtDisable),
    .strapCtrl  (strapCtrl),
    .statusEvent(statusEvent),
    .strb       (strb),
    .rdData     (rdData),
    .intLow     (intLow),
    .ctrlOut    (ctrlOut)
  );

  assign mdioOe   = chanOe & ~{CHANS{powerDown}};
  assign intLowOe = intLow & ~{CHANS{powerDown}};
endmodule

// File: rtl/mdio_sect_slave_chk.sv
module mdio_sect_slave_chk
  import mdio_sect_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sectionMode,
  input logic             mgmtDisable,
  input logic             powerDown,
  input logic [CHANS-1:0] mdioOut,
  input logic [CHANS-1:0] mdioOe,
  input logic [CHANS-1:0] intLowOe
);
  assert_ta_zero_ch0_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe[0]) |-> mdioOut[0] == 1'b0);

  assert_ta_zero_ch1_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe[1]) |-> mdioOut[1] == 1'b0);

  assert_shared_ch1_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sectionMode |-> (!mdioOe[1] && !intLowOe[1]));

  assert_disable_no_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    mgmtDisable |-> mdioOe == '0);

  assert_powerdown_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> (mdioOe == '0 && intLowOe == '0));
endmodule

bind mdio_sect_slave mdio_sect_slave_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sectionMode(sectionMode),
  .mgmtDisable(mgmtDisable),
  .powerDown  (powerDown),
  .mdioOut    (mdioOut),
  .mdioOe     (mdioOe),
  .intLowOe   (intLowOe)
);

// File: tb/sim_mdio_sect_slave.sv
module sim_mdio_sect_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_MDC   = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic         sectionMode, mgmtDisable, powerDown;
  logic [15:0]  strapCtrl;
  logic [7:0]   statusEvent;
  logic [1:0]   mdc, mdioDrv, busLine;
  logic [1:0]   mdioOut, mdioOe, intLowOe;
  logic [127:0] ctrlOut;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign busLine = (mdioOe & mdioOut) | (~mdioOe & mdioDrv);

  mdio_sect_slave u0 (
    .clk(clk), .rstN(rstN), .sectionMode(sectionMode), .mgmtDisable(mgmtDisable),
    .powerDown(powerDown), .strapCtrl(strapCtrl), .statusEvent(statusEvent),
    .mdcIn(mdc), .mdioIn(busLine), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .intLowOe(intLowOe), .ctrlOut(ctrlOut)
  );

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendBit(input int ch, input logic b, output logic s, output logic o);
    mdc[ch] = 1'b0;
    mdioDrv[ch] = b;
    repeat (HALF_MDC) @(negedge clk);
    s = busLine[ch];
    o = mdioOe[ch];
    mdc[ch] = 1'b1;
    repeat (HALF_MDC) @(negedge clk);
  endtask

  task automatic runFrame(input int ch, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, output logic [15:0] rd, output logic ta1Oe,
                          output logic ta2Bit, output int oeCnt);
    logic s, o;
    logic [11:0] hdr;
    hdr = {op, phy, ra};
    rd = '0;
    oeCnt = 0;
    for (int i = 0; i < 32; i++) sendBit(ch, 1'b1, s, o);
    sendBit(ch, 1'b0, s, o);
    sendBit(ch, 1'b1, s, o);
    for (int i = 11; i >= 0; i--) sendBit(ch, hdr[i], s, o);
    sendBit(ch, 1'b1, s, o);
    ta1Oe = o;
    oeCnt += int'(o);
    sendBit(ch, (op == 2'b01) ? 1'b0 : 1'b1, s, o);
    ta2Bit = s;
    oeCnt += int'(o);
    for (int i = 15; i >= 0; i--) begin
      sendBit(ch, (op == 2'b01) ? wd[i] : 1'b1, s, o);
      rd[i] = s;
      oeCnt += int'(o);
    end
    sendBit(ch, 1'b1, s, o);
    oeCnt += int'(o);
  endtask

  task automatic wr(input int ch, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rd;
    logic t1, t2;
    int oc;
    runFrame(ch, 2'b01, phy, ra, wd, rd, t1, t2, oc);
  endtask

  task automatic rdReg(input int ch, input logic [4:0] phy, input logic [4:0] ra,
                       output logic [15:0] rd, output int oc, output logic t1, output logic t2);
    runFrame(ch, 2'b10, phy, ra, 16'h0000, rd, t1, t2, oc);
  endtask

  task automatic doReset(input logic mode, input logic dis);
    rstN = 1'b0;
    sectionMode = mode;
    mgmtDisable = dis;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseEvent(input int p);
    statusEvent[p] = 1'b1;
    @(negedge clk);
    statusEvent = '0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] patVal(input int p, input logic [15:0] salt);
    return salt ^ (16'h0111 * 16'(p + 1));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic t1, t2;
    int oc;
    int ch;
    rstN = 1'b0;
    sectionMode = 1'b0;
    mgmtDisable = 1'b0;
    powerDown = 1'b0;
    strapCtrl = 16'hA5C3;
    statusEvent = '0;
    mdc = 2'b00;
    mdioDrv = 2'b11;

    doReset(1'b0, 1'b0);
    check("R1", "oe after reset", 128'(mdioOe), 128'(0));
    check("R1", "int after reset", 128'(intLowOe), 128'(0));
    check("R1", "ctrl strap load", ctrlOut, {8{16'hA5C3}});
    rdReg(0, 5'd0, 5'd18, rv, oc, t1, t2);
    check("R1", "reg18 reset", 128'(rv), 128'(0));
    rdReg(0, 5'd7, 5'd19, rv, oc, t1, t2);
    check("R1", "reg19 reset", 128'(rv), 128'(0));

    // Shared mode sweep over all ports on channel 0
    for (int p = 0; p < 8; p++) wr(0, 5'(p), 5'd0, patVal(p, 16'h3C00));
    for (int p = 0; p < 8; p++) begin
      rdReg(0, 5'(p), 5'd0, rv, oc, t1, t2);
      check("R2", "readback shared", 128'(rv), 128'(patVal(p, 16'h3C00)));
      check("R3", "drive bit count", 128'(oc), 128'(17));
      check("R3", "ta1 released", 128'(t1), 128'(0));
      check("R3", "ta2 zero", 128'(t2), 128'(0));
      check("R2", "ctrlOut slice", 128'(ctrlOut[p*16 +: 16]), 128'(patVal(p, 16'h3C00)));
    end
    check("R4", "ch0 reaches port 7", 128'(ctrlOut[127:112]), 128'(patVal(7, 16'h3C00)));
    rdReg(1, 5'd5, 5'd0, rv, oc, t1, t2);
    check("R4", "ch1 silent", 128'(oc), 128'(0));
    wr(1, 5'd5, 5'd0, 16'hDEAD);
    rdReg(0, 5'd5, 5'd0, rv, oc, t1, t2);
    check("R4", "ch1 write ignored", 128'(rv), 128'(patVal(5, 16'h3C00)));

    // Address range and opcode filtering
    rdReg(0, 5'd9, 5'd0, rv, oc, t1, t2);
    check("R6", "out of range no drive", 128'(oc), 128'(0));
    runFrame(0, 2'b11, 5'd3, 5'd0, 16'h0000, rv, t1, t2, oc);
    check("R6", "opcode 11 no drive", 128'(oc), 128'(0));
    runFrame(0, 2'b00, 5'd3, 5'd0, 16'h0000, rv, t1, t2, oc);
    check("R6", "opcode 00 no drive", 128'(oc), 128'(0));
    check("R6", "port3 untouched", 128'(ctrlOut[63:48]), 128'(patVal(3, 16'h3C00)));

    // Register map
    wr(0, 5'd2, 5'd7, 16'hFFFF);
    rdReg(0, 5'd2, 5'd7, rv, oc, t1, t2);
    check("R7", "unmapped reads zero", 128'(rv), 128'(0));
    check("R7", "unmapped still driven", 128'(oc), 128'(17));
    wr(0, 5'd2, 5'd19, 16'hFFFF);
    rdReg(0, 5'd2, 5'd19, rv, oc, t1, t2);
    check("R7", "reg19 read-only", 128'(rv), 128'(0));
    wr(0, 5'd2, 5'd18, 16'h0002);
    rdReg(0, 5'd2, 5'd18, rv, oc, t1, t2);
    check("R7", "reg18 readback", 128'(rv), 128'(16'h0002));

    // Interrupts
    pulseEvent(2);
    check("R9", "enabled flag pulls low", 128'(intLowOe), 128'(2'b01));
    rdReg(0, 5'd2, 5'd19, rv, oc, t1, t2);
    check("R8", "flag read", 128'(rv), 128'(1));
    check("R9", "cleared after read", 128'(intLowOe), 128'(0));
    rdReg(0, 5'd2, 5'd19, rv, oc, t1, t2);
    check("R8", "flag cleared", 128'(rv), 128'(0));
    pulseEvent(4);
    check("R9", "disabled port no int", 128'(intLowOe), 128'(0));
    rdReg(0, 5'd4, 5'd19, rv, oc, t1, t2);
    check("R8", "flag set without enable", 128'(rv), 128'(1));

    // Power-down
    pulseEvent(2);
    powerDown = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", "int released", 128'(intLowOe), 128'(0));
    rdReg(0, 5'd2, 5'd0, rv, oc, t1, t2);
    check("R12", "no drive in powerdown", 128'(oc), 128'(0));
    powerDown = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "flag kept", 128'(intLowOe), 128'(2'b01));
    rdReg(0, 5'd2, 5'd0, rv, oc, t1, t2);
    check("R12", "register kept", 128'(rv), 128'(patVal(2, 16'h3C00)));
    rdReg(0, 5'd2, 5'd19, rv, oc, t1, t2);

    // Strap changes after reset
    strapCtrl = 16'h1234;
    repeat (3) @(negedge clk);
    check("R11", "strap ignored after reset", 128'(ctrlOut[15:0]), 128'(patVal(0, 16'h3C00)));

    // Split mode
    doReset(1'b1, 1'b0);
    check("R1", "strap reload", ctrlOut, {8{16'h1234}});
    for (int p = 0; p < 8; p++) begin
      ch = (p < 4) ? 0 : 1;
      wr(ch, 5'(p), 5'd0, patVal(p, 16'h5A00));
      wr(1 - ch, 5'(p), 5'd0, 16'hBAD0 | 16'(p));
    end
    for (int p = 0; p < 8; p++) begin
      ch = (p < 4) ? 0 : 1;
      rdReg(ch, 5'(p), 5'd0, rv, oc, t1, t2);
      check("R5", "own group readback", 128'(rv), 128'(patVal(p, 16'h5A00)));
      rdReg(1 - ch, 5'(p), 5'd0, rv, oc, t1, t2);
      check("R5", "other group no drive", 128'(oc), 128'(0));
    end
    wr(1, 5'd6, 5'd18, 16'h0002);
    pulseEvent(6);
    check("R9", "ch1 interrupt only", 128'(intLowOe), 128'(2'b10));
    rdReg(1, 5'd6, 5'd19, rv, oc, t1, t2);
    check("R8", "ch1 flag read", 128'(rv), 128'(1));
    check("R9", "ch1 int cleared", 128'(intLowOe), 128'(0));

    // Management disabled
    strapCtrl = 16'h0F0F;
    doReset(1'b0, 1'b1);
    rdReg(0, 5'd1, 5'd0, rv, oc, t1, t2);
    check("R10", "no drive when disabled", 128'(oc), 128'(0));
    wr(0, 5'd1, 5'd0, 16'h0000);
    check("R10", "write ignored", 128'(ctrlOut[31:16]), 128'(16'h0F0F));
    strapCtrl = 16'h7777;
    @(negedge clk);
    check("R10", "ctrl follows strap", ctrlOut, {8{16'h7777}});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule